// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer reached over a small synchronous 16-bit register bus. Software picks a timeout in whole half-second units and sets the enable bit in the control register. From then on, an external half-second tick drives an 8-bit countdown. To keep the system alive, software writes a two-word key to the service register before the countdown runs out. If the countdown expires, the block drives a reset request for a fixed number of clocks. It also notes in a read-only status register that the last reset came from the watchdog. When the pulse ends, the block disables itself. Software can then enable it again.

Three registers sit at halfword offsets: control at 0x0, service at 0x2 and status at 0x4. Reads return data in the same cycle and writes take effect at the next clock edge.

Two state machines do the work.

The key detector has the states KEY_IDLE and KEY_ARMED:
- **arm:** a service write of 0x5555 moves it from any state to KEY_ARMED.
- **fire:** a write of 0xAAAA while in KEY_ARMED returns it to KEY_IDLE and reloads the countdown.
- **break:** any other service write moves it to KEY_IDLE.

The countdown machine has the states CD_OFF, CD_RUN and CD_FIRE:
- **start:** the enabling control write moves it from CD_OFF to CD_RUN.
- **expire:** a tick that arrives while the count is zero moves it from CD_RUN to CD_FIRE.
- **release:** when the pulse counter reaches zero it moves from CD_FIRE to CD_OFF, and the control register is cleared.

Top module: `svc_watchdog`

## Requirements
- R1: The control register is read at offset 0x0 and the status register at 0x4. Offset 0x2 (service) and offset 0x6 read as zero. Writes to offset 0x4 leave the status register unchanged.
- R2: In the control register, bits 15:8 hold the timeout field WT and bit 2 is the enable. Bits 0, 1, 3 and 7 are stored and read back as written. Bits 4 to 6 always read zero.
- R3: Once bit 2 is set, a control write with bit 2 clear does not disable the watchdog. Such a write leaves the running countdown untouched, though it still updates WT and the mode bits.
- R4: While bit 2 is clear, ticks do not move the countdown, no reset is requested, and service sequences have no effect.
- R5: The write that sets bit 2 loads the countdown from the WT value in that same write. The reset request then rises on the (WT+1)th tick after that write.
- R6: A service write of 0x5555 followed by a service write of 0xAAAA reloads the countdown from the current WT. The reset request then rises on the (WT+1)th tick after the 0xAAAA write.
- R7: A service write of 0xAAAA without a directly preceding 0x5555 has no effect, and any other value written after 0x5555 breaks the sequence. A repeated 0x5555 keeps the sequence armed.
- R8: The reset request stays high for exactly PULSE_CYCLES clocks, which is 4 by default.
- R9: After rst_n the status register reads 0x0001 (bit 0 means power-on). After a watchdog timeout it reads 0x0002 (bit 1 means watchdog), and it keeps that value through later timeouts until the next rst_n.
- R10: When the reset pulse ends, the control register reads 0x0000 and the watchdog is disabled until it is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_addr | input | ADDR_W (3) | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, same cycle |
| tick_half | input | 1 | One-clock pulse every half second |
| wdog_rst_req | output | 1 | System reset request pulse |

## Verification
The timeout is swept over all 256 WT values, each time counting ticks from the enabling write to the rising reset request. This exposes any off-by-one in loading or expiry, and it also checks the pulse width and the status and control values left after each timeout.

Service sequences are driven in four forms: intact, broken by a third value, a lone 0xAAAA, and a doubled 0x5555. Each is given after a known number of ticks, so the tick count to expiry shows whether a reload happened.

Ticks and service writes are also applied while the watchdog is disabled. Control writes that try to clear the enable show that the enable is sticky while WT still changes.

// File: rtl/svc_wdog_pkg.sv
package svc_wdog_pkg;

    localparam int DATA_W   = 16;
    localparam int WT_W     = 8;
    localparam int WT_LSB   = 8;
    localparam int EN_BIT   = 2;
    localparam int NUM_MODE = 4;
    localparam int MODE_POS [NUM_MODE] = '{0, 1, 3, 7};

    localparam int OFS_CTRL = 0;
    localparam int OFS_SVC  = 2;
    localparam int OFS_STAT = 4;

    localparam int STAT_POR_BIT = 0;
    localparam int STAT_WDT_BIT = 1;

    localparam logic [DATA_W-1:0] KEY_ARM  = 16'h5555;
    localparam logic [DATA_W-1:0] KEY_FIRE = 16'hAAAA;

    typedef enum logic {
        KEY_IDLE,
        KEY_ARMED
    } key_state_t;

    typedef enum logic [1:0] {
        CD_OFF,
        CD_RUN,
        CD_FIRE
    } cd_state_t;

endpackage

// File: rtl/svc_wdog_ctrl.sv
module svc_wdog_ctrl
    import svc_wdog_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              soft_clr,
    input  logic              set_cause,
    output logic              ctrl_en,
    output logic [WT_W-1:0]   ctrl_wt,
    output logic              en_set,
    output logic [WT_W-1:0]   wt_new,
    output logic              svc_wr,
    output logic [DATA_W-1:0] bus_rdata
);

    logic                ctrl_wr;
    logic [NUM_MODE-1:0] mode_q;
    logic                por_flag;
    logic                wdt_flag;
    logic [DATA_W-1:0]   ctrl_rd;
    logic [DATA_W-1:0]   stat_rd;

    assign ctrl_wr = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
    assign svc_wr  = bus_we && (bus_addr == ADDR_W'(OFS_SVC));
    assign wt_new  = bus_wdata[WT_LSB +: WT_W];
    assign en_set  = ctrl_wr && bus_wdata[EN_BIT] && !ctrl_en && !soft_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            ctrl_wt <= '0;
        end else if (soft_clr) begin
            ctrl_en <= 1'b0;
            ctrl_wt <= '0;
        end else if (ctrl_wr) begin
            ctrl_wt <= wt_new;
            if (bus_wdata[EN_BIT]) begin
                ctrl_en <= 1'b1;
            end
        end
    end

    generate
        for (genvar gi = 0; gi < NUM_MODE; gi++) begin : g_mode
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mode_q[gi] <= 1'b0;
                end else if (soft_clr) begin
                    mode_q[gi] <= 1'b0;
                end else if (ctrl_wr) begin
                    mode_q[gi] <= bus_wdata[MODE_POS[gi]];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            por_flag <= 1'b1;
            wdt_flag <= 1'b0;
        end else if (set_cause) begin
            por_flag <= 1'b0;
            wdt_flag <= 1'b1;
        end
    end

    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[WT_LSB +: WT_W] = ctrl_wt;
        ctrl_rd[EN_BIT] = ctrl_en;
        for (int i = 0; i < NUM_MODE; i++) begin
            ctrl_rd[MODE_POS[i]] = mode_q[i];
        end
    end

    always_comb begin
        stat_rd = '0;
        stat_rd[STAT_POR_BIT] = por_flag;
        stat_rd[STAT_WDT_BIT] = wdt_flag;
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_W'(OFS_CTRL): bus_rdata = ctrl_rd;
            ADDR_W'(OFS_STAT): bus_rdata = stat_rd;
            default:           bus_rdata = '0;
        endcase
    end

    // R3: enable cannot be cleared by software
    a_r3_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_en && !soft_clr |=> ctrl_en);

    // R9: the timeout cause persists until power-on reset
    a_r9_cause_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_flag |=> wdt_flag && !por_flag);

endmodule

// File: rtl/svc_wdog_key.sv
module svc_wdog_key
    import svc_wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              svc_wr,
    input  logic [DATA_W-1:0] svc_data,
    input  logic              flush,
    output logic              reload
);

    key_state_t state_q;
    key_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KEY_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = KEY_IDLE;
        end else if (svc_wr) begin
            unique case (state_q)
                KEY_IDLE:  state_d = (svc_data == KEY_ARM) ? KEY_ARMED : KEY_IDLE;
                KEY_ARMED: state_d = (svc_data == KEY_ARM) ? KEY_ARMED : KEY_IDLE;
                default:   state_d = KEY_IDLE;
            endcase
        end
    end

    always_comb begin
        reload = 1'b0;
        unique case (state_q)
            KEY_IDLE:  reload = 1'b0;
            KEY_ARMED: reload = svc_wr && !flush && (svc_data == KEY_FIRE);
            default:   reload = 1'b0;
        endcase
    end

    // R7: a non-arm write always leaves the detector idle
    a_r7_break_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        svc_wr && (svc_data != KEY_ARM) |=> state_q == KEY_IDLE);

endmodule

// File: rtl/svc_wdog_countdown.sv
module svc_wdog_countdown
    import svc_wdog_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_set,
    input  logic [WT_W-1:0] wt_load,
    input  logic [WT_W-1:0] wt_cur,
    input  logic            reload,
    input  logic            tick,
    output logic            rst_req,
    output logic            soft_clr,
    output logic            set_cause
);

    localparam int PW = $clog2(PULSE_CYCLES + 1);
    localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_CYCLES - 1);

    cd_state_t       state_q;
    cd_state_t       state_d;
    logic [WT_W-1:0] cnt_q;
    logic [PW-1:0]   pulse_q;
    logic            expire;

    assign expire = (state_q == CD_RUN) && !reload && tick && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CD_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CD_OFF:  if (en_set)         state_d = CD_RUN;
            CD_RUN:  if (expire)         state_d = CD_FIRE;
            CD_FIRE: if (pulse_q == '0)  state_d = CD_OFF;
            default: state_d = CD_OFF;
        endcase
    end

    always_comb begin
        rst_req   = 1'b0;
        soft_clr  = 1'b0;
        set_cause = 1'b0;
        unique case (state_q)
            CD_OFF:  ;
            CD_RUN:  set_cause = expire;
            CD_FIRE: begin
                rst_req  = 1'b1;
                soft_clr = (pulse_q == '0);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_q <= '0;
        end else begin
            unique case (state_q)
                CD_OFF: begin
                    if (en_set) cnt_q <= wt_load;
                end
                CD_RUN: begin
                    if (reload) begin
                        cnt_q <= wt_cur;
                    end else if (tick && (cnt_q != '0)) begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                    if (expire) pulse_q <= PULSE_LAST;
                end
                CD_FIRE: begin
                    if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
                    cnt_q <= '0;
                end
                default: ;
            endcase
        end
    end

    // R5: a reset request only begins on a tick
    a_r5_fire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(tick));

    // R6: a key reload takes the current timeout field
    a_r6_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        reload && (state_q == CD_RUN) |=> cnt_q == $past(wt_cur));

    // R8: the pulse does not end early
    a_r8_pulse_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req && (pulse_q != '0) |=> rst_req);

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
    import svc_wdog_pkg::*;
#(
    parameter int ADDR_W       = 3,
    parameter int PULSE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              tick_half,
    output logic              wdog_rst_req
);

    logic            ctrl_en;
    logic [WT_W-1:0] ctrl_wt;
    logic            en_set;
    logic [WT_W-1:0] wt_new;
    logic            svc_wr;
    logic            soft_clr;
    logic            set_cause;
    logic            reload;

    svc_wdog_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .soft_clr  (soft_clr),
        .set_cause (set_cause),
        .ctrl_en   (ctrl_en),
        .ctrl_wt   (ctrl_wt),
        .en_set    (en_set),
        .wt_new    (wt_new),
        .svc_wr    (svc_wr),
        .bus_rdata (bus_rdata)
    );

    svc_wdog_key u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc_wr   (svc_wr),
        .svc_data (bus_wdata),
        .flush    (soft_clr),
        .reload   (reload)
    );

    svc_wdog_countdown #(.PULSE_CYCLES(PULSE_CYCLES)) u_cd (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_set    (en_set),
        .wt_load   (wt_new),
        .wt_cur    (ctrl_wt),
        .reload    (reload),
        .tick      (tick_half),
        .rst_req   (wdog_rst_req),
        .soft_clr  (soft_clr),
        .set_cause (set_cause)
    );

    // R4: no reset request while the enable is clear
    a_r4_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> !wdog_rst_req);

    // R10: the end of the pulse leaves the watchdog disabled
    a_r10_off_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdog_rst_req) |-> !ctrl_en);

endmodule

// File: tb/sim_svc_watchdog.sv
`timescale 1ns/1ps
module sim_svc_watchdog;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tick_half = 1'b0;
    logic        wdog_rst_req;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    svc_watchdog u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .tick_half    (tick_half),
        .wdog_rst_req (wdog_rst_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick1(output bit fired);
        @(negedge clk);
        tick_half = 1'b1;
        @(negedge clk);
        tick_half = 1'b0;
        fired = wdog_rst_req;
    endtask

    task automatic ticks_quiet(input int n, output bit any);
        bit f;
        any = 1'b0;
        for (int i = 0; i < n; i++) begin
            tick1(f);
            if (f) any = 1'b1;
        end
    endtask

    task automatic ticks_to_fire(output int n);
        bit f;
        n = 0; f = 1'b0;
        while (!f && n <= 300) begin
            tick1(f);
            n++;
        end
    endtask

    task automatic pulse_width(output int w);
        w = 0;
        while (wdog_rst_req && w < 50) begin
            w++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int n, w;
        bit any;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(3'd0, d); check(d == 16'h0000, "R2 ctrl after reset", d, 16'h0000);
        rd(3'd4, d); check(d == 16'h0001, "R9 status after reset", d, 16'h0001);
        check(wdog_rst_req == 1'b0, "R4 no request after reset", wdog_rst_req, 0);

        // R1 map
        rd(3'd2, d); check(d == 16'h0000, "R1 service reads zero", d, 0);
        rd(3'd6, d); check(d == 16'h0000, "R1 unused offset reads zero", d, 0);
        wr(3'd4, 16'hFFFF);
        rd(3'd4, d); check(d == 16'h0001, "R1 status write ignored", d, 16'h0001);

        // R2 fields without enable
        wr(3'd0, 16'hFF8B);
        rd(3'd0, d); check(d == 16'hFF8B, "R2 modes and WT stored", d, 16'hFF8B);
        wr(3'd0, 16'hFF7B);
        rd(3'd0, d); check(d == 16'hFF0B, "R2 bits 4-6 read zero", d, 16'hFF0B);

        // R4 disabled: ticks and service sequences do nothing
        ticks_quiet(20, any); check(!any, "R4 ticks while disabled", any, 0);
        wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
        rd(3'd0, d); check(d[2] == 1'b0, "R4 still disabled", d[2], 0);

        // R2/R5 enable with all low bits set
        wr(3'd0, 16'h12FF);
        rd(3'd0, d); check(d == 16'h128F, "R2 enabling write readback", d, 16'h128F);
        ticks_to_fire(n); check(n == 19, "R5 timeout WT=0x12", n, 19);
        pulse_width(w); check(w == 4, "R8 pulse width", w, 4);
        rd(3'd0, d); check(d == 16'h0000, "R10 ctrl cleared", d, 0);
        rd(3'd4, d); check(d == 16'h0002, "R9 status after timeout", d, 16'h0002);

        // R5/R8/R9/R10 sweep of every WT value
        for (int wt = 0; wt < 256; wt++) begin
            wr(3'd0, {wt[7:0], 8'h04});
            ticks_to_fire(n);
            check(n == wt + 1, "R5 sweep ticks to request", n, wt + 1);
            pulse_width(w);
            check(w == 4, "R8 sweep pulse width", w, 4);
            rd(3'd0, d);
            check(d == 16'h0000, "R10 sweep ctrl cleared", d, 0);
            rd(3'd4, d);
            check(d == 16'h0002, "R9 sweep status kept", d, 16'h0002);
        end

        // R6 intact sequence
        wr(3'd0, 16'h0504);
        ticks_quiet(3, any); check(!any, "R6 no early request", any, 0);
        wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
        ticks_to_fire(n); check(n == 6, "R6 reload restarts count", n, 6);
        pulse_width(w);

        // R3/R6 enable sticky, WT updated, reload uses new WT
        wr(3'd0, 16'h0404);
        wr(3'd0, 16'h0200);
        rd(3'd0, d); check(d == 16'h0204, "R3 enable stays set", d, 16'h0204);
        ticks_quiet(2, any); check(!any, "R3 count unchanged by write", any, 0);
        wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
        ticks_to_fire(n); check(n == 3, "R6 reload from current WT", n, 3);
        pulse_width(w);

        // R3 write without enable does not restart the count
        wr(3'd0, 16'h0404);
        ticks_quiet(1, any);
        wr(3'd0, 16'h0900);
        ticks_to_fire(n); check(n == 4, "R3 running count kept", n, 4);
        pulse_width(w);

        // R7 lone 0xAAAA
        wr(3'd0, 16'h0504);
        ticks_quiet(2, any);
        wr(3'd2, 16'hAAAA);
        ticks_to_fire(n); check(n == 4, "R7 lone fire key ignored", n, 4);
        pulse_width(w);

        // R7 broken sequence
        wr(3'd0, 16'h0504);
        ticks_quiet(2, any);
        wr(3'd2, 16'h5555); wr(3'd2, 16'h1234); wr(3'd2, 16'hAAAA);
        ticks_to_fire(n); check(n == 4, "R7 broken sequence ignored", n, 4);
        pulse_width(w);

        // R7 doubled arm keeps sequence armed
        wr(3'd0, 16'h0504);
        ticks_quiet(2, any);
        wr(3'd2, 16'h5555); wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
        ticks_to_fire(n); check(n == 6, "R7 repeated arm reloads", n, 6);
        pulse_width(w);

        // R9 power-on reset restores status
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(3'd4, d); check(d == 16'h0001, "R9 status after rst_n", d, 16'h0001);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule